// File: doc/BRIEF.md
# Serial Data Chunk Framing Engine

This block sits on the device side of a full-duplex serial link and moves Ethernet frames between the host and the device as fixed-size chunks. Each chunk is seventeen 32-bit word beats. On the host-to-device direction, beat 0 carries a control header and beats 1 to 16 carry sixteen payload words. On the device-to-host direction, beats 0 to 15 carry payload words sliced out of a receive frame FIFO and beat 16 carries a status footer. Words travel most significant bit first. This interface shows one whole word per beat strobe.

The footer tells the host four things: whether the chunk held frame data, where a frame started or ended inside it, whether the ending frame was dropped, and whether the header of the same chunk was rejected. It also reports two counts: the receive chunks still pending and the transmit credits left. A transmit payload is forwarded only when its header passes an odd-parity check, requests data and finds a free credit. The credit comes back when the downstream logic frees a transmit buffer. An active-low interrupt prompts the host to start a new chunk when receive data appears or when credits return.

Top module: `chunk_framer`

## Requirements
- R1: A frame is spread over as many chunks as needed. Beats 0 to 15 of each chunk return the next FIFO words in FIFO order, and beat 16 returns the footer.
- R2: Footer bit 21 is set exactly when at least one payload word of the chunk came from the FIFO. Payload beats that carry no frame word return zero.
- R3: When a frame starts inside the chunk, footer bit 20 is set and bits 19:16 hold the beat index (0 to 15) of its first word. Otherwise all of these bits are zero.
- R4: When a frame ends inside the chunk, footer bit 14 is set and bits 11:8 hold the beat index of its last word. Otherwise all of these bits are zero.
- R5: Footer bit 15 is set when the frame that ends in the chunk carried the drop mark on its last word.
- R6: A chunk holds at most one frame start and at most one frame end. A start or end that would be the second of its kind waits at the FIFO head for the next chunk. A frame may end and the next one begin in the same chunk.
- R7: A header is good when its 32 bits have odd parity. A bad header sets footer bit 30 in the same chunk, and its payload is not forwarded.
- R8: A good header with bit 21 set, arriving while a credit is free, causes payload beats 1 to 16 to appear on the transmit output, with the last-word flag on beat 16. It also uses one credit.
- R9: Footer bits 5:1 report the credits left after the current header was handled. A free pulse adds one credit, up to the TX_CREDITS limit. A data header that arrives with zero credits is discarded.
- R10: Footer bits 28:24 hold ceil(FIFO level / 16), saturated at 31.
- R11: Footer bit 0 makes the footer word's parity odd, and all footer bits not named above are zero.
- R12: The interrupt goes low after the pending count rises from zero or the credit count rises from zero. It returns high after the first beat of the next chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| beat_vld | input | 1 | One word beat of the current chunk is exchanged this cycle |
| mosi_word | input | 32 | Host-to-device word: header on beat 0, payload afterwards |
| miso_word | output | 32 | Device-to-host word: payload on beats 0-15, footer on beat 16 |
| rx_data | input | 32 | Receive FIFO head word |
| rx_sof | input | 1 | Head word is the first word of a frame |
| rx_eof | input | 1 | Head word is the last word of a frame |
| rx_drop | input | 1 | Frame ending at the head word was dropped |
| rx_valid | input | 1 | Receive FIFO is not empty |
| rx_level | input | LEVEL_W | Words held in the receive FIFO |
| rx_pop | output | 1 | Head word is consumed this cycle |
| tx_data | output | 32 | Forwarded transmit payload word |
| tx_valid | output | 1 | tx_data holds an accepted payload word |
| tx_last | output | 1 | Last payload word of an accepted chunk |
| tx_free | input | 1 | Pulse: one transmit buffer was released |
| irq_n | output | 1 | Active-low interrupt toward the host |

## Verification
On every cycle, the embedded properties check the following: the beat counter never passes the footer beat, the footer parity is odd, the credit count stays within its bounds, each accepted header takes exactly one credit, offsets and the data-valid flag stay steady inside a chunk, the transmit stream stops after its last word, and the interrupt is released at each chunk start. Some behaviour can only be shown by the bench scenarios. These are the exact packing of two frames across a chunk boundary with correct start and end offsets, the deferral of a second frame end, the drop mark, the rejection of a bad header, discarding when credits run out, the saturation of restored credits, and the pending-chunk count, all compared word by word against a reference model.

// File: rtl/chunk_fmt_pkg.sv
`timescale 1ns/1ps
package chunk_fmt_pkg;
    localparam int unsigned CHUNK_WORDS = 16;
    localparam int unsigned OFS_W       = $clog2(CHUNK_WORDS);
    localparam int unsigned BEAT_W      = $clog2(CHUNK_WORDS + 1);
    localparam int unsigned CNT_W       = 5;
    localparam int unsigned CNT_MAX     = (1 << CNT_W) - 1;

    // Footer / header bit positions
    localparam int unsigned POS_HDR_BAD = 30;
    localparam int unsigned POS_DATA    = 21;
    localparam int unsigned POS_START   = 20;
    localparam int unsigned POS_DROP    = 15;
    localparam int unsigned POS_END     = 14;
    localparam int unsigned LSB_PEND    = 24;
    localparam int unsigned LSB_SOFS    = 16;
    localparam int unsigned LSB_EOFS    = 8;
    localparam int unsigned LSB_CRED    = 1;

    typedef struct packed {
        logic             data_vld;
        logic             start;
        logic [OFS_W-1:0] sofs;
        logic             endv;
        logic [OFS_W-1:0] eofs;
        logic             drop;
    } rx_flags_t;

    typedef struct packed {
        logic             hdr_bad;
        logic [CNT_W-1:0] pend;
        logic [CNT_W-1:0] cred;
        rx_flags_t        rx;
    } footer_t;

    function automatic logic word_par_ok(input logic [31:0] w);
        return ^w;
    endfunction

    function automatic logic [31:0] seal_odd(input logic [31:0] w);
        return {w[31:1], ~(^w[31:1])};
    endfunction

    function automatic logic [31:0] pack_footer(input footer_t f);
        logic [31:0] w;
        w                      = '0;
        w[POS_HDR_BAD]         = f.hdr_bad;
        w[LSB_PEND +: CNT_W]   = f.pend;
        w[POS_DATA]            = f.rx.data_vld;
        w[POS_START]           = f.rx.start;
        w[LSB_SOFS +: OFS_W]   = f.rx.sofs;
        w[POS_DROP]            = f.rx.drop;
        w[POS_END]             = f.rx.endv;
        w[LSB_EOFS +: OFS_W]   = f.rx.eofs;
        w[LSB_CRED +: CNT_W]   = f.cred;
        return seal_odd(w);
    endfunction
endpackage

// File: rtl/rx_chunk_slicer.sv
`timescale 1ns/1ps
module rx_chunk_slicer
    import chunk_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              beat_vld,
    input  logic [BEAT_W-1:0] beat,
    input  logic [31:0]       rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_drop,
    input  logic              rx_valid,
    output logic              rx_pop,
    output logic [31:0]       pay_word,
    output rx_flags_t         flags
);
    logic      in_frame_q;
    rx_flags_t fl_q;
    logic      payload_beat;
    logic      footer_beat;
    logic      second_mark;
    logic      head_usable;

    assign payload_beat = beat_vld && (beat < BEAT_W'(CHUNK_WORDS));
    assign footer_beat  = beat_vld && (beat == BEAT_W'(CHUNK_WORDS));
    assign second_mark  = (rx_sof && fl_q.start) || (rx_eof && fl_q.endv);
    assign head_usable  = rx_sof || in_frame_q;
    assign rx_pop       = payload_beat && rx_valid && head_usable && !second_mark;
    assign pay_word     = rx_pop ? rx_data : '0;
    assign flags        = fl_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            in_frame_q <= 1'b0;
            fl_q       <= '0;
        end else if (footer_beat) begin
            fl_q <= '0;
        end else if (rx_pop) begin
            fl_q.data_vld <= 1'b1;
            if (rx_sof) begin
                fl_q.start <= 1'b1;
                fl_q.sofs  <= beat[OFS_W-1:0];
            end
            if (rx_eof) begin
                fl_q.endv <= 1'b1;
                fl_q.eofs <= beat[OFS_W-1:0];
                fl_q.drop <= rx_drop;
            end
            in_frame_q <= !rx_eof;
        end
    end

    // R2: data-valid flag, once set, holds until the footer beat
    a_r2_dv_holds: assert property (@(posedge clk) disable iff (srst)
        (fl_q.data_vld && !footer_beat) |=> fl_q.data_vld);
    // R3: start offset does not move once a start was recorded in the chunk
    a_r3_sofs_stable: assert property (@(posedge clk) disable iff (srst)
        (fl_q.start && !footer_beat) |=> (fl_q.start && $stable(fl_q.sofs)));
    // R4: end offset does not move once an end was recorded in the chunk
    a_r4_eofs_stable: assert property (@(posedge clk) disable iff (srst)
        (fl_q.endv && !footer_beat) |=> (fl_q.endv && $stable(fl_q.eofs)));
endmodule

// File: rtl/tx_hdr_check.sv
`timescale 1ns/1ps
module tx_hdr_check
    import chunk_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              beat_vld,
    input  logic [BEAT_W-1:0] beat,
    input  logic [31:0]       mosi_word,
    input  logic              credit_ok,
    output logic              take,
    output logic              hdr_bad,
    output logic [31:0]       tx_data,
    output logic              tx_valid,
    output logic              tx_last
);
    logic hdr_beat;
    logic par_good;
    logic acc_q;
    logic bad_q;

    assign hdr_beat = beat_vld && (beat == '0);
    assign par_good = word_par_ok(mosi_word);
    assign take     = hdr_beat && par_good && mosi_word[POS_DATA] && credit_ok;

    always_ff @(posedge clk) begin
        if (srst) begin
            acc_q <= 1'b0;
            bad_q <= 1'b0;
        end else if (hdr_beat) begin
            acc_q <= take;
            bad_q <= !par_good;
        end
    end

    assign hdr_bad  = bad_q;
    assign tx_valid = beat_vld && (beat != '0) && acc_q;
    assign tx_data  = mosi_word;
    assign tx_last  = tx_valid && (beat == BEAT_W'(CHUNK_WORDS));

    // R8: the forwarded stream stops after its last word
    a_r8_last_ends: assert property (@(posedge clk) disable iff (srst)
        tx_last |=> !tx_valid);
    // R7: a rejected header never opens a forwarded payload
    a_r7_bad_blocks: assert property (@(posedge clk) disable iff (srst)
        (hdr_beat && !par_good) |=> (hdr_bad && !acc_q));
endmodule

// File: rtl/credit_irq.sv
`timescale 1ns/1ps
module credit_irq
    import chunk_fmt_pkg::*;
#(
    parameter int unsigned TX_CREDITS = 8,
    parameter int unsigned LEVEL_W    = 10
) (
    input  logic               clk,
    input  logic               srst,
    input  logic               take,
    input  logic               tx_free,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               chunk_start,
    output logic               credit_ok,
    output logic [CNT_W-1:0]   credits,
    output logic [CNT_W-1:0]   pend,
    output logic               irq_n
);
    localparam int unsigned SUM_W = LEVEL_W + 1;

    logic [SUM_W-1:0] lvl_chunks;
    logic [CNT_W-1:0] cred_q;
    logic [CNT_W-1:0] cred_d;
    logic             pend_zero_q;
    logic             irq_q;
    logic             rx_event;
    logic             tx_event;

    assign lvl_chunks = (SUM_W'(rx_level) + SUM_W'(CHUNK_WORDS - 1)) >> OFS_W;
    assign pend       = (lvl_chunks > SUM_W'(CNT_MAX)) ? CNT_W'(CNT_MAX)
                                                       : lvl_chunks[CNT_W-1:0];

    always_comb begin
        cred_d = cred_q;
        if (take)
            cred_d = cred_d - 1'b1;
        if (tx_free && (cred_d < CNT_W'(TX_CREDITS)))
            cred_d = cred_d + 1'b1;
    end

    assign rx_event  = pend_zero_q && (pend != '0);
    assign tx_event  = (cred_q == '0) && (cred_d != '0);
    assign credit_ok = (cred_q != '0);
    assign credits   = cred_q;
    assign irq_n     = ~irq_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            cred_q      <= CNT_W'(TX_CREDITS);
            pend_zero_q <= 1'b1;
            irq_q       <= 1'b0;
        end else begin
            cred_q      <= cred_d;
            pend_zero_q <= (pend == '0);
            if (rx_event || tx_event)
                irq_q <= 1'b1;
            else if (chunk_start)
                irq_q <= 1'b0;
        end
    end

    // R9: credit count never exceeds its limit
    a_r9_credit_cap: assert property (@(posedge clk) disable iff (srst)
        cred_q <= CNT_W'(TX_CREDITS));
    // R8: an accepted header uses exactly one credit
    a_r8_take_one: assert property (@(posedge clk) disable iff (srst)
        (take && !tx_free) |=> (cred_q == $past(cred_q) - CNT_W'(1)));
    // R12: a chunk start with no new event releases the interrupt
    a_r12_irq_release: assert property (@(posedge clk) disable iff (srst)
        (chunk_start && !rx_event && !tx_event) |=> irq_n);
endmodule

// File: rtl/chunk_framer.sv
`timescale 1ns/1ps
module chunk_framer
    import chunk_fmt_pkg::*;
#(
    parameter int unsigned TX_CREDITS = 8,
    parameter int unsigned LEVEL_W    = 10
) (
    input  logic               clk,
    input  logic               srst,
    input  logic               beat_vld,
    input  logic [31:0]        mosi_word,
    output logic [31:0]        miso_word,
    input  logic [31:0]        rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_drop,
    input  logic               rx_valid,
    input  logic [LEVEL_W-1:0] rx_level,
    output logic               rx_pop,
    output logic [31:0]        tx_data,
    output logic               tx_valid,
    output logic               tx_last,
    input  logic               tx_free,
    output logic               irq_n
);
    logic [BEAT_W-1:0] beat_q;
    logic              footer_beat;
    logic              chunk_start;
    logic [31:0]       pay_word;
    rx_flags_t         rx_fl;
    logic              take;
    logic              hdr_bad;
    logic              credit_ok;
    logic [CNT_W-1:0]  credits;
    logic [CNT_W-1:0]  pend;
    footer_t           ftr;

    assign footer_beat = (beat_q == BEAT_W'(CHUNK_WORDS));
    assign chunk_start = beat_vld && (beat_q == '0);

    always_ff @(posedge clk) begin
        if (srst)
            beat_q <= '0;
        else if (beat_vld)
            beat_q <= footer_beat ? '0 : beat_q + 1'b1;
    end

    rx_chunk_slicer u_slicer (
        .clk      (clk),
        .srst     (srst),
        .beat_vld (beat_vld),
        .beat     (beat_q),
        .rx_data  (rx_data),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_drop  (rx_drop),
        .rx_valid (rx_valid),
        .rx_pop   (rx_pop),
        .pay_word (pay_word),
        .flags    (rx_fl)
    );

    tx_hdr_check u_hdr (
        .clk       (clk),
        .srst      (srst),
        .beat_vld  (beat_vld),
        .beat      (beat_q),
        .mosi_word (mosi_word),
        .credit_ok (credit_ok),
        .take      (take),
        .hdr_bad   (hdr_bad),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last)
    );

    credit_irq #(
        .TX_CREDITS (TX_CREDITS),
        .LEVEL_W    (LEVEL_W)
    ) u_cred (
        .clk         (clk),
        .srst        (srst),
        .take        (take),
        .tx_free     (tx_free),
        .rx_level    (rx_level),
        .chunk_start (chunk_start),
        .credit_ok   (credit_ok),
        .credits     (credits),
        .pend        (pend),
        .irq_n       (irq_n)
    );

    always_comb begin
        ftr.hdr_bad = hdr_bad;
        ftr.pend    = pend;
        ftr.cred    = credits;
        ftr.rx      = rx_fl;
    end

    assign miso_word = footer_beat ? pack_footer(ftr) : pay_word;

    // R1: the beat index never runs past the footer beat
    a_r1_beat_range: assert property (@(posedge clk) disable iff (srst)
        beat_q <= BEAT_W'(CHUNK_WORDS));
    // R11: every footer leaves with odd parity
    a_r11_footer_odd: assert property (@(posedge clk) disable iff (srst)
        (beat_vld && footer_beat) |-> (^miso_word));
    // R1: no FIFO word is consumed on the footer beat
    a_r1_no_pop_footer: assert property (@(posedge clk) disable iff (srst)
        (beat_vld && footer_beat) |-> !rx_pop);
endmodule

// File: tb/chunk_framer_tb.sv
`timescale 1ns/1ps
module chunk_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CRED   = 8;

    logic        clk = 1'b0;
    logic        srst;
    logic        beat_vld;
    logic [31:0] mosi_word;
    logic [31:0] miso_word;
    logic [31:0] rx_data;
    logic        rx_sof, rx_eof, rx_drop, rx_valid;
    logic [9:0]  rx_level;
    logic        rx_pop;
    logic [31:0] tx_data;
    logic        tx_valid, tx_last;
    logic        tx_free;
    logic        irq_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        bit          is_ftr;
        bit          pop;
        logic [31:0] word;
        bit          txv;
        bit          txl;
        logic [31:0] txd;
    } exp_t;

    exp_t        exp_q[$];
    logic [34:0] fifo_q[$];   // {drop, eof, sof, data}

    // reference model state
    bit       m_in, m_sv, m_ev, m_fd, m_dv, m_acc, m_hb;
    int       m_swo, m_ewo;
    int       m_cred = MAX_CRED;

    always #(CLK_PERIOD/2) clk = ~clk;

    chunk_framer u_dut (
        .clk(clk), .srst(srst), .beat_vld(beat_vld), .mosi_word(mosi_word),
        .miso_word(miso_word), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_drop(rx_drop), .rx_valid(rx_valid),
        .rx_level(rx_level), .rx_pop(rx_pop), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_free(tx_free),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic upd_head();
        if (fifo_q.size() > 0) begin
            {rx_drop, rx_eof, rx_sof, rx_data} = fifo_q[0];
            rx_valid = 1'b1;
        end else begin
            {rx_drop, rx_eof, rx_sof, rx_data} = '0;
            rx_valid = 1'b0;
        end
        rx_level = 10'(fifo_q.size());
    endtask

    task automatic push_frame(input logic [31:0] base, input int len, input bit drop);
        for (int i = 0; i < len; i++)
            fifo_q.push_back({(drop && i == len-1), (i == len-1), (i == 0), base + 32'(i)});
        upd_head();
    endtask

    function automatic logic [31:0] mk_hdr(input bit dv);
        logic [31:0] w;
        w = '0;
        w[21] = dv;
        w[0] = ~(^w[31:1]);
        return w;
    endfunction

    function automatic logic [31:0] model_footer();
        logic [31:0] w;
        int rca;
        rca = (fifo_q.size() + 15) / 16;
        if (rca > 31) rca = 31;
        w = '0;
        w[30]    = m_hb;
        w[28:24] = 5'(rca);
        w[21]    = m_dv;
        w[20]    = m_sv;
        w[19:16] = 4'(m_swo);
        w[15]    = m_fd;
        w[14]    = m_ev;
        w[11:8]  = 4'(m_ewo);
        w[5:1]   = 5'(m_cred);
        w[0]     = ~(^w[31:1]);
        return w;
    endfunction

    // driver: runs one chunk and queues the expected device behaviour
    task automatic do_chunk(input logic [31:0] hdr, input logic [31:0] base);
        bit pend_pop;
        logic [34:0] head;
        exp_t e;
        pend_pop = 0;
        m_sv = 0; m_ev = 0; m_fd = 0; m_dv = 0; m_swo = 0; m_ewo = 0;
        for (int b = 0; b <= 16; b++) begin
            @(posedge clk); #1;
            if (pend_pop) begin
                void'(fifo_q.pop_front());
                upd_head();
            end
            pend_pop = 0;
            beat_vld = 1'b1;
            mosi_word = (b == 0) ? hdr : base + 32'(b);
            e = '{default: '0};
            e.is_ftr = (b == 16);
            if (b == 0) begin
                m_hb  = !(^hdr);
                m_acc = (^hdr) && hdr[21] && (m_cred > 0);
                if (m_acc) m_cred--;
            end
            if (b < 16) begin
                if (fifo_q.size() > 0) begin
                    head = fifo_q[0];
                    if ((head[32] || m_in) && !(head[32] && m_sv) && !(head[33] && m_ev)) begin
                        e.pop = 1; e.word = head[31:0]; pend_pop = 1; m_dv = 1;
                        if (head[32]) begin m_sv = 1; m_swo = b; end
                        if (head[33]) begin m_ev = 1; m_ewo = b; m_fd = head[34]; end
                        m_in = !head[33];
                    end
                end
            end else begin
                e.word = model_footer();
            end
            e.txv = m_acc && (b != 0);
            e.txl = m_acc && (b == 16);
            e.txd = base + 32'(b);
            exp_q.push_back(e);
        end
        @(posedge clk); #1;
        beat_vld = 1'b0;
        mosi_word = '0;
    endtask

    task automatic free_one();
        @(posedge clk); #1;
        tx_free = 1'b1;
        if (m_cred < MAX_CRED) m_cred++;
        @(posedge clk); #1;
        tx_free = 1'b0;
    endtask

    // monitor: compares every beat against the scoreboard queue
    always @(negedge clk) begin
        exp_t e;
        if (!srst && beat_vld) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected beat", 64'(1), 64'(0));
            end else begin
                e = exp_q.pop_front();
                chk("R6 pop", 64'(rx_pop), 64'(e.pop));
                chk("R8 tx flags", {62'(0), tx_valid, tx_last}, {62'(0), e.txv, e.txl});
                if (e.txv) chk("R8 tx data", 64'(tx_data), 64'(e.txd));
                if (e.is_ftr) begin
                    chk("R2 data valid", 64'(miso_word[21]), 64'(e.word[21]));
                    chk("R3 start", 64'(miso_word[20:16]), 64'(e.word[20:16]));
                    chk("R4 end", 64'({miso_word[14], miso_word[11:8]}), 64'({e.word[14], e.word[11:8]}));
                    chk("R5 drop", 64'(miso_word[15]), 64'(e.word[15]));
                    chk("R7 header bad", 64'(miso_word[30]), 64'(e.word[30]));
                    chk("R9 credits", 64'(miso_word[5:1]), 64'(e.word[5:1]));
                    chk("R10 pending", 64'(miso_word[28:24]), 64'(e.word[28:24]));
                    chk("R11 footer word", 64'(miso_word), 64'(e.word));
                end else begin
                    chk(e.pop ? "R1 payload" : "R2 idle payload", 64'(miso_word), 64'(e.word));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        srst = 1'b1; beat_vld = 1'b0; mosi_word = '0; tx_free = 1'b0; m_in = 0;
        upd_head();
        repeat (3) @(posedge clk);
        #1 srst = 1'b0;
        @(negedge clk);
        chk("R12 reset irq", 64'(irq_n), 64'(1));
        chk("R6 reset pop", 64'(rx_pop), 64'(0));
        chk("R8 reset tx", 64'(tx_valid), 64'(0));

        // two frames: 20 words, then 5 words ending with a drop mark
        @(posedge clk); #1;
        push_frame(32'hA000_0000, 20, 0);
        push_frame(32'hB000_0000, 5, 1);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R12 irq on rx data", 64'(irq_n), 64'(0));

        do_chunk(mk_hdr(0), 32'h1000_0000);   // R1: A0..A15, start at 0
        @(negedge clk);
        chk("R12 irq released", 64'(irq_n), 64'(1));
        do_chunk(mk_hdr(0), 32'h1100_0000);   // R4/R3/R6: A ends at 3, B starts at 4, B end deferred
        do_chunk(mk_hdr(0), 32'h1200_0000);   // R4/R5: B ends at 0 with drop
        do_chunk(mk_hdr(0), 32'h1300_0000);   // R2: empty chunk

        do_chunk(mk_hdr(1) ^ 32'h1, 32'h2000_0000);  // R7: bad parity, discarded
        for (int k = 0; k < MAX_CRED; k++)
            do_chunk(mk_hdr(1), 32'h3000_0000 + 32'(k << 8));  // R8: forwarded
        do_chunk(mk_hdr(1), 32'h4000_0000);   // R9: no credit, discarded

        free_one();
        @(negedge clk);
        chk("R12 irq on credit restore", 64'(irq_n), 64'(0));
        do_chunk(mk_hdr(0), 32'h5000_0000);   // R9: one credit reported
        @(negedge clk);
        chk("R12 irq released after chunk", 64'(irq_n), 64'(1));
        for (int k = 0; k < MAX_CRED + 1; k++) free_one();
        do_chunk(mk_hdr(0), 32'h6000_0000);   // R9: saturated at limit
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 scoreboard drained", 64'(exp_q.size()), 64'(0));
        finish_run();
    end
endmodule